// File: doc/BRIEF.md
# External Interrupt Edge Flag Controller

This block collects interrupt events from four external pins and three timer sources into one 8-bit flag register and drives one request line for each source. Each external pin is brought into the clock domain through a two-flop synchronizer. An edge detector compares the newest synchronized sample with the one before it. A 2-bit sensitivity code per pin, kept in a separate control register, decides which edges count. Timer events set their flags directly, one clock after they are seen.

Software reaches both registers over a simple 8-bit register bus with an address, a write strobe, write data and registered read data. A flag is sticky. It clears only in two ways: software writes a 0 to it, or the acknowledge bit for that source is pulsed. Writing a 1 to a flag does nothing. Priority arbitration, vector generation and the timers themselves live outside this block.

Top module: `xint_flag_ctrl`

## Requirements
- R1: After a synchronous reset, the flag register, the sensitivity register, `irq_req` and `sfr_rdata` are all 0.
- R2: The sensitivity register is at address A7h and reads back all 8 bits exactly as written. Bits [2i+1:2i] belong to external pin i: pin 0 uses bits 1:0 and pin 3 uses bits 7:6.
- R3: Sensitivity code 00 ignores the pin, 01 reacts to a rising edge, 10 to a falling edge, and 11 to both edges.
- R4: A selected edge on `ext_pin[i]` sets flag bit i of the flag register at address A6h. The flag becomes visible on `irq_req` after the third rising clock edge that follows the pin change.
- R5: A one-cycle pulse on `tmr_evt[0]`, `tmr_evt[1]` or `tmr_evt[2]` sets flag bit 5, 6 or 7 respectively, and the flag is visible after the next clock edge.
- R6: A set flag stays at 1 while it has no clear condition.
- R7: Writing to A6h clears every flag bit whose written value is 0. Flag bits written with 1 keep their value.
- R8: A pulse on `irq_ack[b]` clears flag bit b.
- R9: If a source event and a clear (a software write of 0 or an acknowledge) arrive in the same cycle, the flag ends up set.
- R10: Flag bit 4 always reads 0, ignores writes and events, and `irq_req[4]` is always 0.
- R11: Changing a sensitivity code while a pin holds a steady level sets no flag.
- R12: `irq_req` equals the flag register bit for bit.
- R13: `sfr_rdata` is registered. After a clock edge it shows the register selected by `sfr_addr` at that edge, and 0 for any address other than A6h or A7h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Registered read data |
| ext_pin | input | 4 | Asynchronous external interrupt pins |
| tmr_evt | input | 3 | Timer event pulses (bit0: flag 5, bit1: flag 6, bit2: flag 7) |
| irq_ack | input | 8 | Per-flag acknowledge pulses, aligned with the flag bits |
| irq_req | output | 8 | Per-flag interrupt requests |

## Verification
The bench checks each sensitivity code on rising and falling pin transitions. A design that decoded the fields wrongly would flag the disabled pin or miss the falling-only pin. It measures the exact three-edge latency from a pin change to the request, which exposes a missing or extra synchronizer stage. It writes all ones to the flag register, which would wipe or set flags in a design that wrongly obeys written 1s, and which would make bit 4 readable if it were not masked. It also collides an event with both a write of 0 and an acknowledge in the same cycle, where the wrong priority loses the event, and changes a code while a pin sits high, which catches a design that mistakes the code change for an edge.

// File: rtl/xint_pkg.sv
package xint_pkg;

  typedef enum logic [1:0] {
    SENSE_OFF  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  function automatic logic edge_hit(input logic [1:0] code, input logic now_v, input logic old_v);
    logic rose, fell;
    rose = now_v & ~old_v;
    fell = ~now_v & old_v;
    return (code[0] & rose) | (code[1] & fell);
  endfunction

endpackage

// File: rtl/xint_pin_edge.sv
module xint_pin_edge
  import xint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic [1:0] sense_i,
  output logic       evt_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur_s;

  assign cur_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= cur_s;
    end
  end

  assign evt_o = edge_hit(sense_i, cur_s, prev_q);

  assert_off_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (sense_i == SENSE_OFF) |-> !evt_o);

  assert_rise_only_R3: assert property (@(posedge clk) disable iff (rst)
    (sense_i == SENSE_RISE && evt_o) |-> cur_s);

  assert_fall_only_R3: assert property (@(posedge clk) disable iff (rst)
    (sense_i == SENSE_FALL && evt_o) |-> !cur_s);

endmodule

// File: rtl/xint_flag_bank.sv
module xint_flag_bank #(
  parameter int          W         = 8,
  parameter logic [W-1:0] USED_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] wr_clr_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] flag_o
);

  logic [W-1:0] flag_q;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      if (USED_MASK[b]) begin : g_live
        always_ff @(posedge clk) begin
          if (rst) flag_q[b] <= 1'b0;
          else     flag_q[b] <= set_i[b] | (flag_q[b] & ~(wr_clr_i[b] | ack_i[b]));
        end

        assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
          set_i[b] |=> flag_q[b]);

        assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
          (ack_i[b] && !set_i[b]) |=> !flag_q[b]);

        assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
          (!set_i[b] && !wr_clr_i[b] && !ack_i[b]) |=> $stable(flag_q[b]));
      end else begin : g_dead
        always_ff @(posedge clk) flag_q[b] <= 1'b0;

        assert_dead_zero_R10: assert property (@(posedge clk) disable iff (rst)
          !flag_q[b]);
      end
    end
  endgenerate

  assign flag_o = flag_q;

endmodule

// File: rtl/xint_sfr_port.sv
module xint_sfr_port #(
  parameter int            DW        = 8,
  parameter int            AW        = 8,
  parameter logic [AW-1:0] FLAG_ADDR = 8'hA6,
  parameter logic [AW-1:0] SENS_ADDR = 8'hA7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] flag_i,
  output logic [DW-1:0] sense_o,
  output logic [DW-1:0] wr_clr_o,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] sense_q;
  logic [DW-1:0] rdata_q;
  logic          hit_flag, hit_sense;

  assign hit_flag  = (addr_i == FLAG_ADDR);
  assign hit_sense = (addr_i == SENS_ADDR);

  always_ff @(posedge clk) begin
    if (rst) sense_q <= '0;
    else if (we_i && hit_sense) sense_q <= wdata_i;
  end

  assign wr_clr_o = (we_i && hit_flag) ? ~wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst)            rdata_q <= '0;
    else if (hit_flag)  rdata_q <= flag_i;
    else if (hit_sense) rdata_q <= sense_q;
    else                rdata_q <= '0;
  end

  assign sense_o = sense_q;
  assign rdata_o = rdata_q;

  assert_sense_write_R2: assert property (@(posedge clk) disable iff (rst)
    (we_i && hit_sense) |=> (sense_q == $past(wdata_i)));

  assert_sense_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(we_i && hit_sense) |=> $stable(sense_q));

  assert_read_other_R13: assert property (@(posedge clk) disable iff (rst)
    (!hit_flag && !hit_sense) |=> (rdata_q == '0));

endmodule

// File: rtl/xint_flag_ctrl.sv
module xint_flag_ctrl
  import xint_pkg::*;
#(
  parameter int          DW          = 8,
  parameter int          AW          = 8,
  parameter int          N_EXT       = 4,
  parameter int          N_TMR       = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  FLAG_ADDR   = 8'hA6,
  parameter logic [7:0]  SENS_ADDR   = 8'hA7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    sfr_addr,
  input  logic             sfr_we,
  input  logic [DW-1:0]    sfr_wdata,
  output logic [DW-1:0]    sfr_rdata,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic [N_TMR-1:0] tmr_evt,
  input  logic [DW-1:0]    irq_ack,
  output logic [DW-1:0]    irq_req
);

  localparam int TMR_LSB = DW - N_TMR;

  function automatic logic [DW-1:0] build_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < N_EXT; i++) m[i] = 1'b1;
    for (int i = 0; i < N_TMR; i++) m[TMR_LSB+i] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] USED_MASK = build_mask();

  logic [N_EXT-1:0] ext_evt;
  logic [DW-1:0]    set_vec;
  logic [DW-1:0]    sense;
  logic [DW-1:0]    wr_clr;
  logic [DW-1:0]    flags;

  genvar p;
  generate
    for (p = 0; p < N_EXT; p++) begin : g_pin
      xint_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (ext_pin[p]),
        .sense_i (sense[2*p+1:2*p]),
        .evt_o   (ext_evt[p])
      );
    end
  endgenerate

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < N_EXT; i++) set_vec[i] = ext_evt[i];
    for (int i = 0; i < N_TMR; i++) set_vec[TMR_LSB+i] = tmr_evt[i];
  end

  xint_sfr_port #(
    .DW(DW), .AW(AW), .FLAG_ADDR(FLAG_ADDR), .SENS_ADDR(SENS_ADDR)
  ) u_sfr (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (sfr_addr),
    .we_i     (sfr_we),
    .wdata_i  (sfr_wdata),
    .flag_i   (flags),
    .sense_o  (sense),
    .wr_clr_o (wr_clr),
    .rdata_o  (sfr_rdata)
  );

  xint_flag_bank #(.W(DW), .USED_MASK(USED_MASK)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set_vec),
    .wr_clr_i (wr_clr),
    .ack_i    (irq_ack),
    .flag_o   (flags)
  );

  assign irq_req = flags;

  assert_write_one_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (sfr_we && sfr_addr == FLAG_ADDR && sfr_wdata[0] && !irq_ack[0] && !set_vec[0])
      |=> $stable(irq_req[0]));

  assert_timer_sets_R5: assert property (@(posedge clk) disable iff (rst)
    tmr_evt[0] |=> irq_req[TMR_LSB]);

endmodule

// File: tb/sim_xint_flag_ctrl.sv
`timescale 1ns/1ps
module sim_xint_flag_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = 8'h00;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic [3:0] ext_pin = 4'h0;
  logic [2:0] tmr_evt = 3'h0;
  logic [7:0] irq_ack = 8'h00;
  logic [7:0] irq_req;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_go = 1'b0;
  logic       mon_pending = 1'b0;

  always #2 clk = ~clk;

  xint_flag_ctrl u0 (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ext_pin(ext_pin),
    .tmr_evt(tmr_evt), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  always @(posedge clk) mon_pending <= rd_go;

  always @(negedge clk) begin
    if (mon_pending) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (sfr_rdata !== e) begin
        failures++;
        $display("FAIL %s read: actual=%02h expected=%02h", t, sfr_rdata, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    sfr_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_go = 1'b1;
    @(negedge clk);
    rd_go = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic chk_req(input logic [7:0] e, input string t);
    checks++;
    if (irq_req !== e) begin
      failures++;
      $display("FAIL %s req: actual=%02h expected=%02h", t, irq_req, e);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    chk_req(8'h00, "R1");
    rd(8'hA6, 8'h00, "R1 flags");
    rd(8'hA7, 8'h00, "R1 sense");

    // pin3 both, pin2 falling, pin1 rising, pin0 off
    wr(8'hA7, 8'hE4);
    rd(8'hA7, 8'hE4, "R2");

    ext_pin = 4'hF;
    tick(4);
    chk_req(8'h0A, "R3 rising");
    rd(8'hA6, 8'h0A, "R4 rising");
    ext_pin = 4'h0;
    tick(4);
    chk_req(8'h0E, "R3 falling");
    rd(8'hA6, 8'h0E, "R12 falling");

    wr(8'hA6, 8'h00);
    chk_req(8'h00, "R7 clear all");

    // latency: change at a negedge, set after the third posedge
    ext_pin = 4'h2;
    tick(2);
    chk_req(8'h00, "R4 early");
    tick(1);
    chk_req(8'h02, "R4 latency");

    wr(8'hA6, 8'hFF);
    chk_req(8'h02, "R7 write one");
    rd(8'hA6, 8'h02, "R10 bit4");
    wr(8'hA6, 8'hFD);
    rd(8'hA6, 8'h00, "R7 write zero");

    @(negedge clk); tmr_evt = 3'b111;
    @(negedge clk); tmr_evt = 3'b000;
    chk_req(8'hE0, "R5 timers");
    tick(6);
    chk_req(8'hE0, "R6 sticky");

    @(negedge clk); irq_ack = 8'h50;
    @(negedge clk); irq_ack = 8'h00;
    chk_req(8'hA0, "R8 ack");
    @(negedge clk); irq_ack = 8'h20;
    @(negedge clk); irq_ack = 8'h00;
    chk_req(8'h80, "R8 ack bit5");

    // event, write-0 and ack together on bit5
    @(negedge clk);
    tmr_evt = 3'b001; irq_ack = 8'h20;
    sfr_addr = 8'hA6; sfr_wdata = 8'h00; sfr_we = 1'b1;
    @(negedge clk);
    tmr_evt = 3'b000; irq_ack = 8'h00; sfr_we = 1'b0;
    chk_req(8'h20, "R9 collision");

    wr(8'hA6, 8'h00);
    wr(8'hA7, 8'h00);
    ext_pin = 4'h6;
    tick(4);
    chk_req(8'h00, "R3 off");
    wr(8'hA7, 8'h30);
    tick(4);
    chk_req(8'h00, "R11 sense change");
    rd(8'hA6, 8'h00, "R11 flags");
    ext_pin = 4'h2;
    tick(4);
    chk_req(8'h04, "R3 both falling");

    rd(8'h55, 8'h00, "R13 other addr");
    rd(8'hA7, 8'h30, "R13 sense");

    tick(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule